// File: doc/BRIEF.md
# Bus Read-Request Traffic Generator

This block is a fixed, self-running sequencer that exercises a memory system through a packet-bus port. Once reset is released it prepares the port, pulses a start/stop line, then issues a block-read request. It presents a 68-bit header word together with a request-type code, and it drives the send and load strobes with exact cycle timing. After a programmed pause it jumps back and issues the same read again, and it keeps doing so for as long as it runs.

The program has five steps: port preparation, start/stop pulse, read issue, wait and jump. Each step keeps its own cycle counter. A step that completes moves the sequencer to the next step and clears the counter. The jump step loads the step index of the read step directly. Every output is registered, so an output shows the decision made from the step and counter values present at the previous clock edge. The block drives the header cycle only. It does no arbitration, no reply handling, no parity generation and no data cycles.

Top module: `rdreq_traffic_gen`

## Requirements
- R1: While `rst_n` is low, every output is 0. The low level takes effect without waiting for a clock edge. After `rst_n` rises, `load_o` first reads 1 after the third rising clock edge.
- R2: Port preparation step. Counting from that first cycle, `load_o` is 1 for 4 cycles and then 0 for 1 cycle. In these cycles `send_o`, `ss_o` and `req_type_o` are 0, and auxiliary word k (`aux_o[8k+7:8k]`, k = 0..4) holds the value k.
- R3: Start/stop step. For 5 cycles `ss_o`=0 and `load_o`=1. For the next 6 cycles `ss_o`=1 and `load_o`=1. For 1 further cycle both are 0.
- R4: Read step. For 2 cycles `send_o`=1 and `load_o`=1. For the next 2 cycles `send_o`=0 and `load_o`=1. For 1 further cycle both are 0. From the first read cycle onward, `req_type_o` is 16 (binary 10000).
- R5: Header layout, from bit 0 upward. Bit 0 is the marker and is 1. Bit 1 (parity), bits 2-3, bit 9 and bit 10 are all 0. Bits 8:4 hold the command, whose value is 0. Bits 20:11 hold the device ID, whose value is 0. Bits 35:21 are 0. The header is 0 until the first read cycle and changes only in read cycles.
- R6: The fixed request address is 0x01234567. Its two 16-bit halves are swapped, and the result goes to bits 67:36 with its LSB at bit 36. Bits 67:36 therefore read 0x45670123, and the whole header reads 68'h45670123000000001.
- R7: After the read step, all strobes stay low for 11 wait cycles and 1 jump cycle. The read step then repeats, so one read begins every 17 cycles, indefinitely.
- R8: `err_o` is a sticky error flag. It stays 0 throughout normal operation. An invalid step index would force all strobes to 0 and set the flag until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hdr_o | output | 68 | Header word of the read request |
| req_type_o | output | 5 | Request-type code (16 for a low-priority length-2 read) |
| aux_o | output | 40 | Five 8-bit auxiliary bus words, word k at bits 8k+7:8k |
| send_o | output | 1 | Send strobe |
| load_o | output | 1 | Load strobe |
| ss_o | output | 1 | Start/stop line |
| err_o | output | 1 | Sticky error flag for an invalid step index |

## Verification
The functions most likely to collide are the end of one step and the first strobe of the next. At the start/stop-to-read boundary, `load_o` is low for exactly one cycle and then returns high in the same cycle in which `send_o` rises, `req_type_o` changes to 16 and the header is captured. The second collision is a reset asserted in the middle of a read loop while the strobes are high. The bench checks every strobe against a cycle-indexed schedule derived from the requirements, over more than two full loops, so an off-by-one at either boundary fails at once. It also asserts reset in the middle of a loop and requires every output to clear before the next edge, then the same schedule to restart from the beginning.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  localparam int CMD_W    = 5;
  localparam int DEV_W    = 10;
  localparam int ADDR_W   = 32;
  localparam int MARK_BIT = 0;
  localparam int CMD_LSB  = 4;
  localparam int DEV_LSB  = 11;
  localparam int ADDR_LSB = 36;
  localparam int HDR_W    = ADDR_LSB + ADDR_W;
  localparam int HALF_W   = ADDR_W / 2;

  typedef enum logic [2:0] {
    ST_PREP  = 3'd0,
    ST_SS    = 3'd1,
    ST_READ  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_JUMP  = 3'd4
  } step_e;

  // Swap the two halves of the address word.
  function automatic logic [ADDR_W-1:0] swap_halves(input logic [ADDR_W-1:0] a);
    return {a[HALF_W-1:0], a[ADDR_W-1:HALF_W]};
  endfunction

  // Build a request header from its fields; every unnamed bit stays 0.
  function automatic logic [HDR_W-1:0] build_hdr(
    input logic [CMD_W-1:0]  cmd,
    input logic [DEV_W-1:0]  dev,
    input logic [ADDR_W-1:0] addr
  );
    logic [HDR_W-1:0] h;
    h                    = '0;
    h[MARK_BIT]          = 1'b1;
    h[CMD_LSB +: CMD_W]  = cmd;
    h[DEV_LSB +: DEV_W]  = dev;
    h[ADDR_LSB +: ADDR_W] = swap_halves(addr);
    return h;
  endfunction

endpackage

// File: rtl/rtg_rst_sync.sv
module rtg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/rtg_step_seq.sv
module rtg_step_seq
  import rtg_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int PREP_LEN  = 4,
  parameter int SS_LOW    = 5,
  parameter int SS_HI_END = 10,
  parameter int READ_LEN  = 4,
  parameter int WAIT_CYC  = 10
) (
  input  logic             clk,
  input  logic             srst_n,
  output step_e            step_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bad_o
);

  localparam logic [CNT_W-1:0] PREP_LAST = CNT_W'(PREP_LEN);
  localparam logic [CNT_W-1:0] SS_LAST   = CNT_W'(SS_HI_END);
  localparam logic [CNT_W-1:0] READ_LAST = CNT_W'(READ_LEN);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(SS_HI_END + 1);

  step_e            step_q, step_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bad_d;

  // Next step and counter: each step counts, then clears the counter and advances.
  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q + CNT_W'(1);
    bad_d  = 1'b0;
    case (step_q)
      ST_PREP: begin
        if (cnt_q >= PREP_LAST) begin
          cnt_d  = '0;
          step_d = ST_SS;
        end
      end
      ST_SS: begin
        if (cnt_q > SS_LAST) begin
          cnt_d  = '0;
          step_d = ST_READ;
        end
      end
      ST_READ: begin
        if (cnt_q >= READ_LAST) begin
          cnt_d  = '0;
          step_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cnt_q >= WAIT_LAST) begin
          cnt_d  = '0;
          step_d = ST_JUMP;
        end
      end
      ST_JUMP: begin
        cnt_d  = cnt_q;
        step_d = ST_READ;
      end
      default: begin
        cnt_d  = cnt_q;
        bad_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      step_q <= ST_PREP;
      cnt_q  <= '0;
    end else begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
    end
  end

  assign step_o = step_q;
  assign cnt_o  = cnt_q;
  assign bad_o  = bad_d;

  // R7: the jump step always lands on the read step
  p_jump_to_read_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (step_q == ST_JUMP) |=> (step_q == ST_READ));

  // R2: the preparation step leaves after its last count
  p_prep_exit_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (step_q == ST_PREP && cnt_q == PREP_LAST) |=> (step_q == ST_SS && cnt_q == '0));

  // R3: no step counts past the end of the start/stop step
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= CNT_MAX);

  // R3: the start/stop step ends only from its final count
  p_ss_exit_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (step_q == ST_SS && cnt_q < CNT_MAX) |=> (step_q == ST_SS));

endmodule

// File: rtl/rtg_strobe_gen.sv
module rtg_strobe_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int PREP_LEN  = 4,
  parameter int SS_LOW    = 5,
  parameter int SS_HI_END = 10,
  parameter int SEND_LEN  = 2,
  parameter int READ_LEN  = 4,
  parameter int REQ_W     = 5,
  parameter int REQ_READ  = 16,
  parameter int AUX_N     = 5,
  parameter int AUX_W     = 8
) (
  input  logic                   clk,
  input  logic                   srst_n,
  input  step_e                  step_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic                   bad_i,
  output logic                   send_o,
  output logic                   load_o,
  output logic                   ss_o,
  output logic                   err_o,
  output logic [REQ_W-1:0]       req_o,
  output logic [AUX_N*AUX_W-1:0] aux_o
);

  localparam logic [CNT_W-1:0] PREP_LAST  = CNT_W'(PREP_LEN);
  localparam logic [CNT_W-1:0] SS_LO_LAST = CNT_W'(SS_LOW);
  localparam logic [CNT_W-1:0] SS_LAST    = CNT_W'(SS_HI_END);
  localparam logic [CNT_W-1:0] SEND_LAST  = CNT_W'(SEND_LEN);
  localparam logic [CNT_W-1:0] READ_LAST  = CNT_W'(READ_LEN);
  localparam logic [REQ_W-1:0] REQ_CODE   = REQ_W'(REQ_READ);

  logic             send_q, send_d;
  logic             load_q, load_d;
  logic             ss_q, ss_d;
  logic             err_q, err_d;
  logic [REQ_W-1:0] req_q, req_d;
  logic             aux_en;

  // Strobe decisions for the current step and count; untouched strobes hold.
  always_comb begin
    send_d = send_q;
    load_d = load_q;
    ss_d   = ss_q;
    req_d  = req_q;
    err_d  = err_q | bad_i;
    aux_en = 1'b0;
    case (step_i)
      ST_PREP: begin
        req_d  = '0;
        send_d = 1'b0;
        ss_d   = 1'b0;
        load_d = (cnt_i < PREP_LAST);
        aux_en = 1'b1;
      end
      ST_SS: begin
        ss_d   = (cnt_i >= SS_LO_LAST) && (cnt_i <= SS_LAST);
        load_d = (cnt_i <= SS_LAST);
      end
      ST_READ: begin
        req_d  = REQ_CODE;
        send_d = (cnt_i < SEND_LAST);
        load_d = (cnt_i < READ_LAST);
      end
      ST_WAIT, ST_JUMP: begin
      end
      default: begin
        send_d = 1'b0;
        load_d = 1'b0;
        ss_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      send_q <= 1'b0;
      load_q <= 1'b0;
      ss_q   <= 1'b0;
      err_q  <= 1'b0;
      req_q  <= '0;
    end else begin
      send_q <= send_d;
      load_q <= load_d;
      ss_q   <= ss_d;
      err_q  <= err_d;
      req_q  <= req_d;
    end
  end

  // One register per auxiliary word, loaded with its own index.
  for (genvar k = 0; k < AUX_N; k++) begin : g_aux
    logic [AUX_W-1:0] word_q;
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)     word_q <= '0;
      else if (aux_en) word_q <= AUX_W'(k);
    end
    assign aux_o[k*AUX_W +: AUX_W] = word_q;
  end

  assign send_o = send_q;
  assign load_o = load_q;
  assign ss_o   = ss_q;
  assign err_o  = err_q;
  assign req_o  = req_q;

  // R4: send is never high without load
  p_send_needs_load_r4: assert property (@(posedge clk) disable iff (!srst_n)
    send_q |-> load_q);

  // R3: start/stop and send never overlap
  p_ss_excl_r3: assert property (@(posedge clk) disable iff (!srst_n)
    ss_q |-> !send_q);

  // R4: a send carries the read request code
  p_send_code_r4: assert property (@(posedge clk) disable iff (!srst_n)
    send_q |-> (req_q == REQ_CODE));

  // R8: the error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!srst_n)
    err_q |=> err_q);

endmodule

// File: rtl/rtg_hdr_reg.sv
module rtg_hdr_reg
  import rtg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RD_ADDR = 32'h0123_4567,
  parameter logic [CMD_W-1:0]  RD_CMD  = '0,
  parameter logic [DEV_W-1:0]  DEV_ID  = '0
) (
  input  logic             clk,
  input  logic             srst_n,
  input  step_e            step_i,
  output logic [HDR_W-1:0] hdr_o
);

  logic [HDR_W-1:0] hdr_q;
  logic [HDR_W-1:0] hdr_d;
  logic             hdr_en;

  always_comb begin
    hdr_en = (step_i == ST_READ);
    hdr_d  = build_hdr(RD_CMD, DEV_ID, RD_ADDR);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     hdr_q <= '0;
    else if (hdr_en) hdr_q <= hdr_d;
  end

  assign hdr_o = hdr_q;

  // R5: the header changes only on read cycles
  p_hdr_hold_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !hdr_en |=> $stable(hdr_q));

  // R5: a non-empty header always carries its marker bit
  p_hdr_mark_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (hdr_q != '0) |-> hdr_q[MARK_BIT]);

endmodule

// File: rtl/rdreq_traffic_gen.sv
module rdreq_traffic_gen
  import rtg_pkg::*;
#(
  parameter int                CNT_W     = 5,
  parameter int                PREP_LEN  = 4,
  parameter int                SS_LOW    = 5,
  parameter int                SS_HI_END = 10,
  parameter int                SEND_LEN  = 2,
  parameter int                READ_LEN  = 4,
  parameter int                WAIT_CYC  = 10,
  parameter int                REQ_W     = 5,
  parameter int                REQ_READ  = 16,
  parameter int                AUX_N     = 5,
  parameter int                AUX_W     = 8,
  parameter logic [ADDR_W-1:0] RD_ADDR   = 32'h0123_4567
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [HDR_W-1:0]       hdr_o,
  output logic [REQ_W-1:0]       req_type_o,
  output logic [AUX_N*AUX_W-1:0] aux_o,
  output logic                   send_o,
  output logic                   load_o,
  output logic                   ss_o,
  output logic                   err_o
);

  logic             srst_n;
  step_e            step;
  logic [CNT_W-1:0] cnt;
  logic             bad;

  rtg_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  rtg_step_seq #(
    .CNT_W     (CNT_W),
    .PREP_LEN  (PREP_LEN),
    .SS_LOW    (SS_LOW),
    .SS_HI_END (SS_HI_END),
    .READ_LEN  (READ_LEN),
    .WAIT_CYC  (WAIT_CYC)
  ) u_step_seq (
    .clk    (clk),
    .srst_n (srst_n),
    .step_o (step),
    .cnt_o  (cnt),
    .bad_o  (bad)
  );

  rtg_strobe_gen #(
    .CNT_W     (CNT_W),
    .PREP_LEN  (PREP_LEN),
    .SS_LOW    (SS_LOW),
    .SS_HI_END (SS_HI_END),
    .SEND_LEN  (SEND_LEN),
    .READ_LEN  (READ_LEN),
    .REQ_W     (REQ_W),
    .REQ_READ  (REQ_READ),
    .AUX_N     (AUX_N),
    .AUX_W     (AUX_W)
  ) u_strobe_gen (
    .clk    (clk),
    .srst_n (srst_n),
    .step_i (step),
    .cnt_i  (cnt),
    .bad_i  (bad),
    .send_o (send_o),
    .load_o (load_o),
    .ss_o   (ss_o),
    .err_o  (err_o),
    .req_o  (req_type_o),
    .aux_o  (aux_o)
  );

  rtg_hdr_reg #(
    .RD_ADDR (RD_ADDR)
  ) u_hdr_reg (
    .clk    (clk),
    .srst_n (srst_n),
    .step_i (step),
    .hdr_o  (hdr_o)
  );

  // R1: reset leaves every strobe low
  p_reset_quiet_r1: assert property (@(posedge clk)
    !srst_n |-> (!send_o && !load_o && !ss_o && !err_o));

endmodule

// File: tb/test_rdreq_traffic_gen.sv
`timescale 1ns/1ps
module test_rdreq_traffic_gen;

  localparam logic [67:0] HDR_EXP = 68'h45670123000000001;
  localparam int          PERIOD  = 17;
  localparam int          RD0     = 17;

  logic        clk;
  logic        rst_n;
  logic [67:0] hdr_o;
  logic [4:0]  req_type_o;
  logic [39:0] aux_o;
  logic        send_o, load_o, ss_o, err_o;

  int checks = 0;
  int errors = 0;

  rdreq_traffic_gen i_rdreq_traffic_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_o      (hdr_o),
    .req_type_o (req_type_o),
    .aux_o      (aux_o),
    .send_o     (send_o),
    .load_o     (load_o),
    .ss_o       (ss_o),
    .err_o      (err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected {ss, send, load} after cycle e of the program (e = 0 is the first load cycle).
  function automatic logic [2:0] exp_strobes(input int e);
    int p;
    if (e < 4)        return 3'b001;
    else if (e == 4)  return 3'b000;
    else if (e < 10)  return 3'b001;
    else if (e < 16)  return 3'b101;
    else if (e == 16) return 3'b000;
    p = (e - RD0) % PERIOD;
    if (p < 2)        return 3'b011;
    else if (p < 4)   return 3'b001;
    return 3'b000;
  endfunction

  function automatic string phase_req(input int e);
    int p;
    if (e < 5)  return "R2";
    if (e < 17) return "R3";
    p = (e - RD0) % PERIOD;
    if (p < 5)  return "R4";
    return "R7";
  endfunction

  // Release reset at a falling edge; return edges until load first reads 1.
  task automatic release_and_sync(output int n);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!load_o && n < 20);
  endtask

  task automatic t_reset_state;
    int n;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk({hdr_o, req_type_o, aux_o, send_o, load_o, ss_o, err_o} == '0, "R1",
        "outputs in reset", {send_o, load_o, ss_o, err_o}, 68'h0);
    chk(hdr_o == '0, "R1", "header in reset", hdr_o, 68'h0);
    release_and_sync(n);
    chk(n == 3, "R1", "edges to first load", 68'(n), 68'd3);
  endtask

  // Walk the schedule from e = 0 (already sampled) through e_last.
  task automatic t_trace(input int e_last);
    bit err_seen = 1'b0;
    for (int e = 0; e <= e_last; e++) begin
      if (e > 0) @(negedge clk);
      chk({ss_o, send_o, load_o} == exp_strobes(e), phase_req(e),
          $sformatf("strobes {ss,send,load} at e=%0d", e),
          68'({ss_o, send_o, load_o}), 68'(exp_strobes(e)));
      if (e == 0 || e == 16 || e == RD0 || e == RD0 + PERIOD) begin
        chk(req_type_o == ((e < RD0) ? 5'd0 : 5'd16), (e < RD0) ? "R2" : "R4",
            $sformatf("request type at e=%0d", e), 68'(req_type_o),
            (e < RD0) ? 68'd0 : 68'd16);
        chk(hdr_o == ((e < RD0) ? 68'h0 : HDR_EXP), "R5",
            $sformatf("header at e=%0d", e), hdr_o, (e < RD0) ? 68'h0 : HDR_EXP);
      end
      if (e == 1) begin
        for (int k = 0; k < 5; k++)
          chk(aux_o[k*8 +: 8] == 8'(k), "R2", $sformatf("aux word %0d", k),
              68'(aux_o[k*8 +: 8]), 68'(k));
      end
      if (err_o) err_seen = 1'b1;
    end
    chk(!err_seen, "R8", "error flag stayed low", 68'(err_seen), 68'h0);
  endtask

  task automatic t_header_fields;
    chk(hdr_o[0] == 1'b1, "R5", "marker bit", 68'(hdr_o[0]), 68'h1);
    chk(hdr_o[3:1] == 3'b0 && hdr_o[10:9] == 2'b0, "R5", "parity/spare/mode bits",
        68'({hdr_o[10:9], hdr_o[3:1]}), 68'h0);
    chk(hdr_o[8:4] == 5'd0, "R5", "command field", 68'(hdr_o[8:4]), 68'h0);
    chk(hdr_o[20:11] == 10'd0, "R5", "device ID field", 68'(hdr_o[20:11]), 68'h0);
    chk(hdr_o[35:21] == 15'd0, "R5", "zero field", 68'(hdr_o[35:21]), 68'h0);
    chk(hdr_o[67:36] == 32'h4567_0123, "R6", "swapped address", 68'(hdr_o[67:36]),
        68'h45670123);
    chk(hdr_o == HDR_EXP, "R6", "whole header", hdr_o, HDR_EXP);
  endtask

  // Reset during a read with strobes high; everything must clear, then restart.
  task automatic t_midrun_reset;
    int n;
    while (!(send_o && load_o)) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({send_o, load_o, ss_o, err_o} == 4'b0 && req_type_o == '0, "R1",
        "strobes clear on mid-run reset", 68'({send_o, load_o, ss_o, req_type_o}), 68'h0);
    chk(hdr_o == '0 && aux_o == '0, "R1", "header/aux clear on mid-run reset",
        hdr_o, 68'h0);
    repeat (2) @(negedge clk);
    release_and_sync(n);
    chk(n == 3, "R1", "edges to first load after mid-run reset", 68'(n), 68'd3);
    t_trace(RD0 + 4);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset_state();
    t_trace(RD0 + 2 * PERIOD + 16);
    t_header_fields();
    t_midrun_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule